// File: doc/BRIEF.md
# Exception Entry Vector Generator

This block decides where the processor goes when an exception is accepted, and it updates the exception-state registers that the handler later reads. One strobe cycle carries the exception kind, its cause code, the PC of the faulting instruction, a delay-slot flag and the current status bits. One clock edge later the block presents the handler address, the saved return PC, the branch-delay flag, the cause code and the new status flags. It then holds these until the next entry.

The block has three kinds of ordinary entry: general, TLB miss and interrupt. Reset and NMI requests come in on their own inputs. They outrank any ordinary entry and use a fixed boot vector. Interrupts can be vectored: the highest enabled pending line selects a handler slot whose distance from the base is programmable.

Top module: `exc_vector_gen`

## Requirements
- R1: While `rst_n` is low and after reset, `entry_valid` is 0 and `new_pc`, `epc`, `error_epc`, `cause_code`, `cause_bd` and all status outputs are 0.
- R2: The handler base is 0xBFC00200 when `bev_in` is 1. Otherwise it is `exc_base` with bits [9:0] cleared. A general entry (`kind` = 0 or 3) jumps to base + 0x180.
- R3: A TLB miss (`kind` = 1) jumps to base + 0x000 when `exl_in` is 0 and to base + 0x180 when `exl_in` is 1.
- R4: An interrupt (`kind` = 2) jumps to base + 0x180 when `ivec_en` is 0. It jumps to base + 0x200 when `ivec_en` is 1 and either `bev_in` is 1 or `vec_spacing` is 0.
- R5: For a vectored interrupt (`ivec_en` = 1, `bev_in` = 0, `vec_spacing` not 0), the vector V is the index of the highest set bit of `irq_pending & im_in`, or 0 if no bit is set. The handler address is base + 0x200 + V × `vec_spacing` × 32.
- R6: On an ordinary entry with `exl_in` = 0, `epc` becomes `cur_pc`, or `cur_pc` − 4 when `in_delay_slot` is 1, and `cause_bd` becomes `in_delay_slot`.
- R7: On an ordinary entry with `exl_in` = 1, `epc` and `cause_bd` keep their previous values.
- R8: On an ordinary entry, `cause_code` takes `exc_cause`, and both `status_exl` and `kernel_mode` become 1.
- R9: A reset or NMI entry jumps to 0xBFC00000. It sets `status_erl`, `status_bev` and `kernel_mode`, and loads `error_epc` with `cur_pc` (or `cur_pc` − 4 in a delay slot). It leaves `epc`, `cause_bd` and `cause_code` unchanged.
- R10: Priority is `reset_req` over `nmi_req` over `accept`. A reset entry gives `status_sr` = 1 and `status_nmi` = 0, and an NMI entry gives the reverse.
- R11: Outputs change exactly one clock after a cycle with any request, and `entry_valid` is 1 for that one cycle only. With no request, `entry_valid` is 0 and all other outputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| accept | input | 1 | Ordinary exception accepted this cycle |
| kind | input | 2 | 0 general, 1 TLB miss, 2 interrupt, 3 general |
| exc_cause | input | 5 | Cause code to record |
| reset_req | input | 1 | Soft reset entry request |
| nmi_req | input | 1 | Non-maskable interrupt entry request |
| cur_pc | input | 32 | PC of the faulting instruction |
| in_delay_slot | input | 1 | Faulting instruction sits in a branch delay slot |
| exl_in | input | 1 | Current exception-level flag |
| bev_in | input | 1 | Current boot-vector flag |
| im_in | input | 8 | Interrupt mask |
| ivec_en | input | 1 | Vectored interrupt enable |
| vec_spacing | input | 5 | Vector spacing in units of 32 bytes |
| exc_base | input | 32 | Exception base register |
| irq_pending | input | 8 | Pending interrupt lines |
| entry_valid | output | 1 | One-cycle pulse: outputs just updated |
| new_pc | output | 32 | Handler address |
| epc | output | 32 | Saved return PC |
| error_epc | output | 32 | Saved return PC for reset/NMI |
| cause_code | output | 5 | Recorded cause code |
| cause_bd | output | 1 | Recorded branch-delay flag |
| status_exl | output | 1 | Exception level |
| status_erl | output | 1 | Error level |
| status_bev | output | 1 | Boot vectors |
| status_sr | output | 1 | Entry was a soft reset |
| status_nmi | output | 1 | Entry was an NMI |
| kernel_mode | output | 1 | Kernel mode forced |

## Verification
Handler addresses are checked with the boot-vector flag both set and clear. Under each setting, a TLB miss at both exception levels separates the refill offset from the general one. Interrupts run with vectoring off, with zero spacing and with boot vectors on, which separates the 0x180 and 0x200 cases. Three vectored cases follow: a pending/mask pair where the highest pending line is masked, a pair with no enabled line, and maximum spacing on line 7; together they expose priority, masking and overflow of the product. The saved-PC cases pair a delay-slot entry with a repeat entry at exception level, and combined reset/NMI/ordinary strobes show the priority order.

// File: rtl/exc_vector_gen.sv
module exc_vector_gen #(
  parameter logic [31:0] BOOT_PC  = 32'hBFC0_0000,
  parameter logic [31:0] BOOT_BASE = 32'hBFC0_0200
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        accept,
  input  logic [1:0]  kind,
  input  logic [4:0]  exc_cause,
  input  logic        reset_req,
  input  logic        nmi_req,
  input  logic [31:0] cur_pc,
  input  logic        in_delay_slot,
  input  logic        exl_in,
  input  logic        bev_in,
  input  logic [7:0]  im_in,
  input  logic        ivec_en,
  input  logic [4:0]  vec_spacing,
  input  logic [31:0] exc_base,
  input  logic [7:0]  irq_pending,
  output logic        entry_valid,
  output logic [31:0] new_pc,
  output logic [31:0] epc,
  output logic [31:0] error_epc,
  output logic [4:0]  cause_code,
  output logic        cause_bd,
  output logic        status_exl,
  output logic        status_erl,
  output logic        status_bev,
  output logic        status_sr,
  output logic        status_nmi,
  output logic        kernel_mode
);
  localparam logic [1:0]  K_TLB = 2'd1;
  localparam logic [1:0]  K_INT = 2'd2;
  localparam logic [13:0] OFF_GEN = 14'h180;
  localparam logic [13:0] OFF_VEC = 14'h200;

  logic        boot_entry, any_req;
  logic [31:0] base, resume_pc, vec_pc;
  logic [7:0]  masked, slot_units;
  logic [2:0]  vec;
  logic [13:0] offset;

  assign boot_entry = reset_req | nmi_req;
  assign any_req    = boot_entry | accept;
  assign base       = bev_in ? BOOT_BASE : (exc_base & ~32'h3FF);
  assign resume_pc  = in_delay_slot ? cur_pc - 32'd4 : cur_pc;
  assign masked     = irq_pending & im_in;

  always_comb begin
    vec = 3'd0;
    for (int i = 0; i < 8; i++)
      if (masked[i]) vec = 3'(i);
  end

  assign slot_units = {5'b0, vec} * {3'b0, vec_spacing};

  always_comb begin
    offset = OFF_GEN;
    if (kind == K_TLB && !exl_in)
      offset = 14'h000;
    else if (kind == K_INT && ivec_en) begin
      if (bev_in || vec_spacing == 5'd0) offset = OFF_VEC;
      else offset = OFF_VEC + {1'b0, slot_units, 5'b0};
    end
  end

  assign vec_pc = base + {18'b0, offset};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      entry_valid <= 1'b0;
      new_pc      <= '0;
      epc         <= '0;
      error_epc   <= '0;
      cause_code  <= '0;
      cause_bd    <= 1'b0;
      status_exl  <= 1'b0;
      status_erl  <= 1'b0;
      status_bev  <= 1'b0;
      status_sr   <= 1'b0;
      status_nmi  <= 1'b0;
      kernel_mode <= 1'b0;
    end else begin
      entry_valid <= any_req;
      if (boot_entry) begin
        new_pc      <= BOOT_PC;
        error_epc   <= resume_pc;
        status_exl  <= exl_in;
        status_erl  <= 1'b1;
        status_bev  <= 1'b1;
        status_sr   <= reset_req;
        status_nmi  <= !reset_req;
        kernel_mode <= 1'b1;
      end else if (accept) begin
        new_pc      <= vec_pc;
        cause_code  <= exc_cause;
        if (!exl_in) begin
          epc      <= resume_pc;
          cause_bd <= in_delay_slot;
        end
        status_exl  <= 1'b1;
        status_bev  <= bev_in;
        kernel_mode <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/exc_vector_gen_chk.sv
module exc_vector_gen_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        accept,
  input logic        reset_req,
  input logic        nmi_req,
  input logic        exl_in,
  input logic        entry_valid,
  input logic [31:0] new_pc,
  input logic [31:0] epc,
  input logic        cause_bd,
  input logic        status_exl,
  input logic        status_erl,
  input logic        status_bev,
  input logic        status_sr,
  input logic        status_nmi,
  input logic        kernel_mode
);
  p_valid_after_req_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (accept || reset_req || nmi_req) |=> entry_valid);

  p_quiet_without_req_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(accept || reset_req || nmi_req) |=> (!entry_valid && $stable(new_pc) && $stable(epc)));

  p_epc_kept_at_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && exl_in && !reset_req && !nmi_req) |=> ($stable(epc) && $stable(cause_bd)));

  p_exl_kernel_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !reset_req && !nmi_req) |=> (status_exl && kernel_mode));

  p_boot_vector_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (reset_req || nmi_req) |=> (new_pc == 32'hBFC0_0000 && status_erl && status_bev && kernel_mode));

  p_boot_kind_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (reset_req || nmi_req) |=> ($onehot0({status_sr, status_nmi}) && (status_sr || status_nmi)));

  p_reset_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |=> status_sr);
endmodule

bind exc_vector_gen exc_vector_gen_chk i_chk (.*);

// File: tb/test_exc_vector_gen.sv
module test_exc_vector_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        accept = 1'b0;
  logic [1:0]  kind = '0;
  logic [4:0]  exc_cause = '0;
  logic        reset_req = 1'b0, nmi_req = 1'b0;
  logic [31:0] cur_pc = '0;
  logic        in_delay_slot = 1'b0, exl_in = 1'b0, bev_in = 1'b0;
  logic [7:0]  im_in = '0;
  logic        ivec_en = 1'b0;
  logic [4:0]  vec_spacing = '0;
  logic [31:0] exc_base = 32'h8000_1234;
  logic [7:0]  irq_pending = '0;
  logic        entry_valid, cause_bd;
  logic [31:0] new_pc, epc, error_epc;
  logic [4:0]  cause_code;
  logic        status_exl, status_erl, status_bev, status_sr, status_nmi, kernel_mode;

  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  exc_vector_gen i_exc_vector_gen (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic fire(input logic [1:0] k, input logic [4:0] c, input logic acc,
                      input logic rr, input logic nr);
    @(negedge clk);
    kind = k; exc_cause = c; accept = acc; reset_req = rr; nmi_req = nr;
    @(negedge clk);
    accept = 1'b0; reset_req = 1'b0; nmi_req = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 valid", {31'b0, entry_valid}, 0);
    chk("R1 pc", new_pc, 0);
    chk("R1 epc", epc, 0);
    chk("R1 flags", {status_exl, status_erl, status_bev, status_sr, status_nmi, kernel_mode, cause_bd}, 0);
  endtask

  task automatic t_general;
    bev_in = 0; exl_in = 0;
    fire(2'd0, 5'd4, 1, 0, 0);
    chk("R2 general base", new_pc, 32'h8000_1180);
    chk("R11 valid pulse", {31'b0, entry_valid}, 1);
    chk("R8 cause", {27'b0, cause_code}, 4);
    chk("R8 exl kernel", {30'b0, status_exl, kernel_mode}, 3);
    @(negedge clk);
    chk("R11 valid drops", {31'b0, entry_valid}, 0);
    chk("R11 hold", new_pc, 32'h8000_1180);
    bev_in = 1;
    fire(2'd3, 5'd5, 1, 0, 0);
    chk("R2 general boot", new_pc, 32'hBFC0_0380);
    bev_in = 0;
  endtask

  task automatic t_tlb;
    exl_in = 0; fire(2'd1, 5'd2, 1, 0, 0);
    chk("R3 refill", new_pc, 32'h8000_1000);
    exl_in = 1; fire(2'd1, 5'd2, 1, 0, 0);
    chk("R3 at level", new_pc, 32'h8000_1180);
    exl_in = 0; bev_in = 1; fire(2'd1, 5'd3, 1, 0, 0);
    chk("R3 refill boot", new_pc, 32'hBFC0_0200);
    bev_in = 0;
  endtask

  task automatic t_irq_simple;
    exl_in = 0; ivec_en = 0; vec_spacing = 5'd4; irq_pending = 8'h80; im_in = 8'hFF;
    fire(2'd2, 5'd0, 1, 0, 0);
    chk("R4 no vectoring", new_pc, 32'h8000_1180);
    ivec_en = 1; vec_spacing = 0;
    fire(2'd2, 5'd0, 1, 0, 0);
    chk("R4 zero spacing", new_pc, 32'h8000_1200);
    bev_in = 1; vec_spacing = 5'd4;
    fire(2'd2, 5'd0, 1, 0, 0);
    chk("R4 boot vectors", new_pc, 32'hBFC0_0400);
    bev_in = 0;
  endtask

  task automatic t_irq_vectored;
    ivec_en = 1; vec_spacing = 5'd2; irq_pending = 8'b1010_0110; im_in = 8'b0011_0011;
    fire(2'd2, 5'd0, 1, 0, 0);
    chk("R5 masked highest", new_pc, 32'h8000_1340);
    irq_pending = 8'h0F; im_in = 8'hF0;
    fire(2'd2, 5'd0, 1, 0, 0);
    chk("R5 none enabled", new_pc, 32'h8000_1200);
    vec_spacing = 5'd31; irq_pending = 8'h81; im_in = 8'hFF;
    fire(2'd2, 5'd0, 1, 0, 0);
    chk("R5 max spacing", new_pc, 32'h8000_2D20);
    ivec_en = 0;
  endtask

  task automatic t_epc;
    exl_in = 0; in_delay_slot = 0; cur_pc = 32'h1000_0040;
    fire(2'd0, 5'd8, 1, 0, 0);
    chk("R6 epc plain", epc, 32'h1000_0040);
    chk("R6 bd clear", {31'b0, cause_bd}, 0);
    in_delay_slot = 1;
    fire(2'd0, 5'd8, 1, 0, 0);
    chk("R6 epc slot", epc, 32'h1000_003C);
    chk("R6 bd set", {31'b0, cause_bd}, 1);
    exl_in = 1; in_delay_slot = 0; cur_pc = 32'h2000_0000;
    fire(2'd0, 5'd9, 1, 0, 0);
    chk("R7 epc kept", epc, 32'h1000_003C);
    chk("R7 bd kept", {31'b0, cause_bd}, 1);
    chk("R8 cause at level", {27'b0, cause_code}, 9);
    exl_in = 0;
  endtask

  task automatic t_boot;
    cur_pc = 32'h0000_0020; in_delay_slot = 1; exl_in = 0;
    fire(2'd0, 5'd12, 1, 1, 1);
    chk("R9 boot pc", new_pc, 32'hBFC0_0000);
    chk("R9 error epc", error_epc, 32'h0000_001C);
    chk("R9 erl bev kernel", {29'b0, status_erl, status_bev, kernel_mode}, 7);
    chk("R9 epc untouched", epc, 32'h1000_003C);
    chk("R9 cause untouched", {27'b0, cause_code}, 9);
    chk("R10 reset wins", {30'b0, status_sr, status_nmi}, 2);
    in_delay_slot = 0; cur_pc = 32'h0000_0100;
    fire(2'd0, 5'd12, 1, 0, 1);
    chk("R10 nmi over accept", {30'b0, status_sr, status_nmi}, 1);
    chk("R9 nmi error epc", error_epc, 32'h0000_0100);
    chk("R10 cause untouched", {27'b0, cause_code}, 9);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_general();
        t_tlb();
        t_irq_simple();
        t_irq_vectored();
        t_epc();
        t_boot();
      end
      begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule